// File: doc/BRIEF.md
# Gap-Terminated Receive Byte Packer

This block sits behind a bit-level receiver. Each bit time the receiver raises a strobe, along with a flag that says whether that bit was decoded cleanly (valid) or not. The block packs the valid bits, most significant first, into bytes. A byte is moved into a single holding register when eight bits have been gathered.

A frame ends when a run of consecutive invalid bit times follows valid data. The length of that run is programmable. When a frame ends, any partial byte is flushed into the holding register, left-aligned, and a separate register reports how many of its bits are meaningful.

Four sticky status flags report the following events: data arrival, overrun of the holding register, a read of an empty holding register, and frame end. Each flag has its own interrupt enable, and the enabled flags are combined into one interrupt line. A single control bit can switch the packer off. In that case every valid bit is passed straight through on a registered serial output.

Software reaches the block through a small read/write register port.

Top module: `rx_deser_top`

## Requirements
- R1: After reset, control (address 0) reads 0x0B (packer on, gap length 3). The interrupt enables (address 1) read 0x00, status (address 3) reads 0x00, and `irq` and `serial_valid` are low.
- R2: With the packer on, eight valid bits are packed first bit into bit 7. The resulting byte is placed in the holding register (address 2) on the strobe of the eighth bit. That sets status bit 0 (full), and the count register reads 8.
- R3: A transfer into the holding register while full is set, with no data read in the same cycle, sets status bit 1 (overflow). The newer byte replaces the older one.
- R4: Reading address 2 while full is clear sets status bit 3 (underflow).
- R5: Frame end sets status bit 2 on the (G+1)-th consecutive invalid bit time, where G is control bits 2:0. It fires only when at least one valid bit has arrived since reset or since the previous frame end. A valid bit restarts the invalid-run count. Cycles without a strobe are not bit times.
- R6: At frame end with N (1 to 7) pending bits, the holding register receives those bits left-aligned with the low 8-N bits zero, full is set, and the count register reads N. With zero pending bits, no transfer takes place.
- R7: Reading address 2 clears full. Reading address 3 returns the flags as they were before the read, then clears overflow, underflow and frame end. A flag set in the same cycle wins over the clear.
- R8: `irq` is high one cycle after any status bit is set together with its enable bit at address 1. The enable bits use the same positions as the status bits.
- R9: When control bit 3 is 0, the packer is held empty and never transfers. Each valid strobed bit appears on `serial_out` with `serial_valid` high one cycle later. When control bit 3 is 1, `serial_valid` stays low.
- R10: `reg_rdata` takes the value of the addressed register one cycle after `reg_rd`. The count register is at address 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_strobe | input | 1 | One bit time has elapsed |
| bit_valid | input | 1 | The strobed bit was received cleanly |
| bit_data | input | 1 | Value of the strobed bit |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Registered read data |
| irq | output | 1 | Combined masked interrupt |
| serial_out | output | 1 | Pass-through bit while the packer is off |
| serial_valid | output | 1 | Pass-through bit strobe while the packer is off |

## Verification
The assertions check every cycle that a transfer always sets full, that the overflow and underflow conditions always raise their flags, and that a status read with no concurrent frame end clears the frame-end flag. They also check that the held count stays within 1 to 8 while full, that masked status never drives `irq`, and that no transfer or pass-through strobe appears in the wrong mode. Some behaviours are shown only by the bench's sweep over every gap length and every frame length from 1 to 9 bits: the exact bit time at which frame end fires, the left-aligned flush values, the restart of the run by a valid bit, and the clearing of the packer when it is switched off.

// File: rtl/rx_deser_pkg.sv
package rx_deser_pkg;
  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] A_IE   = 3'd1;
  localparam logic [ADDR_W-1:0] A_DATA = 3'd2;
  localparam logic [ADDR_W-1:0] A_STAT = 3'd3;
  localparam logic [ADDR_W-1:0] A_CNT  = 3'd4;
  localparam int ST_FULL = 0;
  localparam int ST_OVF  = 1;
  localparam int ST_EOF  = 2;
  localparam int ST_UNF  = 3;
  localparam int ST_W    = 4;
endpackage

// File: rtl/rx_deser_shift.sv
module rx_deser_shift #(
  parameter int DW = 8,
  parameter int GW = 3,
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [GW-1:0] gap_len,
  input  logic          strobe,
  input  logic          valid,
  input  logic          din,
  output logic          xfer,
  output logic [DW-1:0] xfer_data,
  output logic [CW-1:0] xfer_cnt,
  output logic          eof
);
  localparam logic [CW-1:0] LAST   = CW'(DW - 1);
  localparam logic [CW-1:0] FULL_C = CW'(DW);

  logic [DW-1:0] sh_q;
  logic [CW-1:0] cnt_q;
  logic [GW-1:0] gap_q;
  logic          armed_q;
  logic          take, idle_bit, fill, gap_hit;

  always_comb begin
    take     = en & strobe & valid;
    idle_bit = en & strobe & ~valid;
    fill     = take & (cnt_q == LAST);
    gap_hit  = idle_bit & armed_q & (gap_q >= gap_len);
    xfer     = fill | (gap_hit & (cnt_q != '0));
    eof      = gap_hit;
    if (fill) begin
      xfer_data = {sh_q[DW-2:0], din};
      xfer_cnt  = FULL_C;
    end else begin
      xfer_data = sh_q << (FULL_C - cnt_q);
      xfer_cnt  = cnt_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      sh_q    <= '0;
      cnt_q   <= '0;
      gap_q   <= '0;
      armed_q <= 1'b0;
    end else if (take) begin
      armed_q <= 1'b1;
      gap_q   <= '0;
      if (fill) begin
        sh_q  <= '0;
        cnt_q <= '0;
      end else begin
        sh_q  <= {sh_q[DW-2:0], din};
        cnt_q <= cnt_q + 1'b1;
      end
    end else if (idle_bit && armed_q) begin
      if (gap_hit) begin
        armed_q <= 1'b0;
        gap_q   <= '0;
        cnt_q   <= '0;
        sh_q    <= '0;
      end else begin
        gap_q <= gap_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/rx_deser_status.sv
module rx_deser_status
  import rx_deser_pkg::*;
#(
  parameter int DW = 8,
  parameter int CW = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            xfer,
  input  logic [DW-1:0]   xfer_data,
  input  logic [CW-1:0]   xfer_cnt,
  input  logic            eof,
  input  logic            rd_data_stb,
  input  logic            rd_stat_stb,
  output logic [DW-1:0]   hold_data,
  output logic [CW-1:0]   hold_cnt,
  output logic [ST_W-1:0] status
);
  always_ff @(posedge clk) begin
    if (rst) begin
      hold_data <= '0;
      hold_cnt  <= '0;
    end else if (xfer) begin
      hold_data <= xfer_data;
      hold_cnt  <= xfer_cnt;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status <= '0;
    end else begin
      if (xfer)             status[ST_FULL] <= 1'b1;
      else if (rd_data_stb) status[ST_FULL] <= 1'b0;

      if (xfer && status[ST_FULL] && !rd_data_stb) status[ST_OVF] <= 1'b1;
      else if (rd_stat_stb)                          status[ST_OVF] <= 1'b0;

      if (rd_data_stb && !status[ST_FULL]) status[ST_UNF] <= 1'b1;
      else if (rd_stat_stb)                 status[ST_UNF] <= 1'b0;

      if (eof)              status[ST_EOF] <= 1'b1;
      else if (rd_stat_stb) status[ST_EOF] <= 1'b0;
    end
  end
endmodule

// File: rtl/rx_deser_csr.sv
module rx_deser_csr
  import rx_deser_pkg::*;
#(
  parameter int DW      = 8,
  parameter int GW      = 3,
  parameter int CW      = 4,
  parameter int GAP_RST = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  input  logic [DW-1:0]     hold_data,
  input  logic [CW-1:0]     hold_cnt,
  input  logic [ST_W-1:0]   status,
  output logic              en,
  output logic [GW-1:0]     gap_len,
  output logic [ST_W-1:0]   ie,
  output logic              rd_data_stb,
  output logic              rd_stat_stb,
  output logic [DW-1:0]     reg_rdata,
  output logic              irq
);
  logic unused_wbits;
  assign unused_wbits = ^reg_wdata;

  assign rd_data_stb = reg_rd && (reg_addr == A_DATA);
  assign rd_stat_stb = reg_rd && (reg_addr == A_STAT);

  always_ff @(posedge clk) begin
    if (rst) begin
      en      <= 1'b1;
      gap_len <= GW'(GAP_RST);
      ie      <= '0;
    end else if (reg_wr) begin
      if (reg_addr == A_CTRL) begin
        en      <= reg_wdata[GW];
        gap_len <= reg_wdata[GW-1:0];
      end
      if (reg_addr == A_IE) ie <= reg_wdata[ST_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else if (reg_rd) begin
      case (reg_addr)
        A_CTRL:  reg_rdata <= DW'({en, gap_len});
        A_IE:    reg_rdata <= DW'(ie);
        A_DATA:  reg_rdata <= hold_data;
        A_STAT:  reg_rdata <= DW'(status);
        A_CNT:   reg_rdata <= DW'(hold_cnt);
        default: reg_rdata <= '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |(status & ie);
  end
endmodule

// File: rtl/rx_deser_top.sv
module rx_deser_top
  import rx_deser_pkg::*;
#(
  parameter int DW      = 8,
  parameter int GW      = 3,
  parameter int GAP_RST = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_strobe,
  input  logic              bit_valid,
  input  logic              bit_data,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  output logic              irq,
  output logic              serial_out,
  output logic              serial_valid
);
  localparam int CW = $clog2(DW + 1);

  logic            en;
  logic [GW-1:0]   gap_len;
  logic [ST_W-1:0] ie;
  logic            rd_data_stb, rd_stat_stb;
  logic            xfer, eof_evt;
  logic [DW-1:0]   xfer_data, hold_data;
  logic [CW-1:0]   xfer_cnt, hold_cnt;
  logic [ST_W-1:0] status;

  rx_deser_shift #(.DW(DW), .GW(GW), .CW(CW)) u_shift (
    .clk(clk), .rst(rst), .en(en), .gap_len(gap_len),
    .strobe(bit_strobe), .valid(bit_valid), .din(bit_data),
    .xfer(xfer), .xfer_data(xfer_data), .xfer_cnt(xfer_cnt), .eof(eof_evt)
  );

  rx_deser_status #(.DW(DW), .CW(CW)) u_status (
    .clk(clk), .rst(rst), .xfer(xfer), .xfer_data(xfer_data),
    .xfer_cnt(xfer_cnt), .eof(eof_evt), .rd_data_stb(rd_data_stb),
    .rd_stat_stb(rd_stat_stb), .hold_data(hold_data), .hold_cnt(hold_cnt),
    .status(status)
  );

  rx_deser_csr #(.DW(DW), .GW(GW), .CW(CW), .GAP_RST(GAP_RST)) u_csr (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .hold_data(hold_data),
    .hold_cnt(hold_cnt), .status(status), .en(en), .gap_len(gap_len),
    .ie(ie), .rd_data_stb(rd_data_stb), .rd_stat_stb(rd_stat_stb),
    .reg_rdata(reg_rdata), .irq(irq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      serial_out   <= 1'b0;
      serial_valid <= 1'b0;
    end else begin
      serial_valid <= bit_strobe & bit_valid & ~en;
      serial_out   <= bit_data & ~en;
    end
  end
endmodule

// File: rtl/rx_deser_checker.sv
module rx_deser_checker
  import rx_deser_pkg::*;
#(
  parameter int DW = 8,
  parameter int CW = 4
) (
  input logic            clk,
  input logic            rst,
  input logic            en,
  input logic            bit_strobe,
  input logic            xfer,
  input logic            eof_evt,
  input logic            rd_data_stb,
  input logic            rd_stat_stb,
  input logic [ST_W-1:0] status,
  input logic [ST_W-1:0] ie,
  input logic [CW-1:0]   hold_cnt,
  input logic            irq,
  input logic            serial_valid
);
  assert_full_on_xfer_R2: assert property (@(posedge clk) disable iff (rst)
    xfer |=> status[ST_FULL]);
  assert_overflow_R3: assert property (@(posedge clk) disable iff (rst)
    (xfer && status[ST_FULL] && !rd_data_stb) |=> status[ST_OVF]);
  assert_underflow_R4: assert property (@(posedge clk) disable iff (rst)
    (rd_data_stb && !status[ST_FULL]) |=> status[ST_UNF]);
  assert_xfer_on_bit_R5: assert property (@(posedge clk) disable iff (rst)
    (xfer || eof_evt) |-> bit_strobe);
  assert_count_range_R6: assert property (@(posedge clk) disable iff (rst)
    status[ST_FULL] |-> (hold_cnt != '0 && hold_cnt <= CW'(DW)));
  assert_eof_clear_R7: assert property (@(posedge clk) disable iff (rst)
    (rd_stat_stb && !eof_evt) |=> !status[ST_EOF]);
  assert_irq_masked_R8: assert property (@(posedge clk) disable iff (rst)
    (ie == '0) |=> !irq);
  assert_no_xfer_off_R9: assert property (@(posedge clk) disable iff (rst)
    !en |-> !xfer);
  assert_quiet_serial_R9: assert property (@(posedge clk) disable iff (rst)
    en |=> !serial_valid);
endmodule

bind rx_deser_top rx_deser_checker #(.DW(DW), .CW(CW)) u_chk (
  .clk(clk), .rst(rst), .en(en), .bit_strobe(bit_strobe), .xfer(xfer),
  .eof_evt(eof_evt), .rd_data_stb(rd_data_stb), .rd_stat_stb(rd_stat_stb),
  .status(status), .ie(ie), .hold_cnt(hold_cnt), .irq(irq),
  .serial_valid(serial_valid)
);

// File: tb/rx_deser_top_bench.sv
module rx_deser_top_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bit_strobe = 1'b0, bit_valid = 1'b0, bit_data = 1'b0;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       irq, serial_out, serial_valid;
  int errors = 0;
  int checks = 0;
  logic [7:0] v;

  always #2 clk = ~clk;

  rx_deser_top u_rx_deser_top (
    .clk(clk), .rst(rst), .bit_strobe(bit_strobe), .bit_valid(bit_valid),
    .bit_data(bit_data), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq(irq), .serial_out(serial_out), .serial_valid(serial_valid)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    @(negedge clk); reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic sb(input logic vld, input logic d);
    @(negedge clk); bit_strobe = 1'b1; bit_valid = vld; bit_data = d;
    @(negedge clk); bit_strobe = 1'b0;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 irq", {7'd0, irq}, 8'h00);
    chk("R1 serial_valid", {7'd0, serial_valid}, 8'h00);
    rd(3'd0, v); chk("R1 ctrl", v, 8'h0B);
    rd(3'd1, v); chk("R1 ie", v, 8'h00);
    rd(3'd3, v); chk("R1 status", v, 8'h00);

    // R5 idle invalid bits before any valid bit: no frame end
    for (int i = 0; i < 10; i++) sb(1'b0, 1'b0);
    rd(3'd3, v); chk("R5 idle no eof", v, 8'h00);

    // Sweep every gap length and frame lengths 1..9
    for (int g = 0; g < 8; g++) begin
      for (int k = 1; k < 10; k++) begin
        logic [8:0] p;
        int rem;
        p = 9'((g * 37 + k * 11) & 'h1ff);
        rem = k % 8;
        wr(3'd0, 8'(8'h08 | g));
        for (int i = 0; i < k; i++) begin
          sb(1'b1, p[k-1-i]);
          if (i == 7) begin
            rd(3'd3, v); chk("R2 full", v & 8'h01, 8'h01);
            rd(3'd4, v); chk("R2 count R10", v, 8'd8);
            rd(3'd2, v); chk("R2 byte", v, 8'(p >> (k - 8)));
          end
        end
        for (int i = 0; i < g; i++) sb(1'b0, 1'b0);
        rd(3'd3, v); chk("R5 before gap end", v & 8'h04, 8'h00);
        sb(1'b0, 1'b0);
        rd(3'd3, v);
        chk("R5 eof on gap end", v & 8'h04, 8'h04);
        chk("R6 full on flush", v & 8'h01, (rem != 0) ? 8'h01 : 8'h00);
        if (rem != 0) begin
          rd(3'd2, v);
          chk("R6 left aligned", v, 8'((int'(p) & ((1 << rem) - 1)) << (8 - rem)));
          rd(3'd4, v); chk("R6 partial count", v, 8'(rem));
        end
        rd(3'd3, v); chk("R7 cleared", v, 8'h00);
      end
    end

    // R5 valid bit restarts the invalid run
    wr(3'd0, 8'h0A);
    sb(1'b1, 1'b1); sb(1'b0, 1'b0); sb(1'b0, 1'b0);
    sb(1'b1, 1'b0); sb(1'b0, 1'b0); sb(1'b0, 1'b0);
    rd(3'd3, v); chk("R5 restart no eof", v, 8'h00);
    sb(1'b0, 1'b0);
    rd(3'd3, v); chk("R5 restart eof", v, 8'h05);
    rd(3'd2, v); chk("R6 two bits", v, 8'h80);
    rd(3'd4, v); chk("R6 two count", v, 8'd2);

    // R3 overflow: newer byte replaces older
    wr(3'd0, 8'h0F);
    for (int i = 7; i >= 0; i--) sb(1'b1, 8'hA5 >> i);
    for (int i = 7; i >= 0; i--) sb(1'b1, 8'h3C >> i);
    rd(3'd3, v); chk("R3 overflow", v, 8'h03);
    rd(3'd2, v); chk("R3 newer byte", v, 8'h3C);
    for (int i = 0; i < 8; i++) sb(1'b0, 1'b0);
    rd(3'd3, v); chk("R6 zero pending no xfer", v, 8'h04);

    // R4 underflow
    rd(3'd2, v);
    rd(3'd3, v); chk("R4 underflow", v, 8'h08);
    rd(3'd3, v); chk("R7 underflow cleared", v, 8'h00);

    // R8 interrupt masking
    wr(3'd1, 8'h04);
    wr(3'd0, 8'h08);
    sb(1'b1, 1'b1); sb(1'b0, 1'b0);
    @(negedge clk); chk("R8 irq eof", {7'd0, irq}, 8'h01);
    rd(3'd3, v);
    @(negedge clk); chk("R8 irq masked full", {7'd0, irq}, 8'h00);
    wr(3'd1, 8'h01);
    @(negedge clk); chk("R8 irq full", {7'd0, irq}, 8'h01);
    rd(3'd2, v); chk("R6 one bit", v, 8'h80);
    @(negedge clk); chk("R8 irq after read", {7'd0, irq}, 8'h00);
    wr(3'd1, 8'h00);

    // R9 bypass mode
    wr(3'd0, 8'h03);
    sb(1'b1, 1'b1);
    chk("R9 pass valid", {7'd0, serial_valid}, 8'h01);
    chk("R9 pass one", {7'd0, serial_out}, 8'h01);
    sb(1'b1, 1'b0);
    chk("R9 pass zero", {6'd0, serial_valid, serial_out}, 8'h02);
    sb(1'b0, 1'b1);
    chk("R9 invalid not passed", {7'd0, serial_valid}, 8'h00);
    for (int i = 0; i < 8; i++) sb(1'b1, 1'b1);
    sb(1'b0, 1'b0); sb(1'b0, 1'b0); sb(1'b0, 1'b0); sb(1'b0, 1'b0);
    rd(3'd3, v); chk("R9 no packing", v, 8'h00);
    wr(3'd0, 8'h08);
    sb(1'b1, 1'b1); sb(1'b1, 1'b0); sb(1'b1, 1'b1);
    chk("R9 quiet when on", {7'd0, serial_valid}, 8'h00);
    wr(3'd0, 8'h00);
    wr(3'd0, 8'h08);
    sb(1'b0, 1'b0); sb(1'b0, 1'b0);
    rd(3'd3, v); chk("R9 packer cleared", v, 8'h00);
    rd(3'd0, v); chk("R10 ctrl readback", v, 8'h08);

    finish_run();
  end
endmodule